// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block is the master phase sequencer of a small 16-bit load/store processor built on a multicycle datapath. It holds one encoded phase and presents it to the fetch, decode, execute, memory-access and writeback units. Each of those units reads the phase and acts on it. Every phase lasts exactly one clock cycle.

An instruction always starts with a fetch phase and a decode phase. During decode the controller reads the 4-bit opcode of the fetched instruction and sorts it into a class: arithmetic/logic, branch/jump, subroutine call, direct load, direct store, indirect load, indirect store, or address-only load. It stores that class for the rest of the instruction. The class selects the phases that follow. Every route ends in a program-counter update phase, and the machine then returns to fetch. Opcodes that do not belong to any class, such as trap and return-from-interrupt, take no action: they go from decode straight to the program-counter update phase.

Top module: `seq_ctrl`

## Requirements
- R1: Phase encoding on `phase`: 0 fetch, 1 decode, 2 execute, 3 address compute, 4 pointer read, 5 data read, 6 data write, 7 register write, 8 link save, 9 PC update. After a clock edge with `rst` high, `phase` is 0.
- R2: Fetch is always followed by decode, and PC update is always followed by fetch.
- R3: Opcodes 0001, 0101 and 1001 follow the route fetch, decode, execute, register write, PC update, which takes 5 cycles.
- R4: Opcodes 0000 and 1100 follow the route fetch, decode, execute, PC update, which takes 4 cycles.
- R5: Opcode 0100 follows the route fetch, decode, execute, link save, PC update, which takes 5 cycles.
- R6: Opcodes 0010 and 0110 follow the route fetch, decode, address compute, data read, register write, PC update, which takes 6 cycles.
- R7: Opcodes 0011 and 0111 follow the route fetch, decode, address compute, data write, PC update, which takes 5 cycles. There is no register write.
- R8: Opcode 1010 follows the route fetch, decode, address compute, pointer read, data read, register write, PC update, which takes 7 cycles.
- R9: Opcode 1011 follows the route fetch, decode, address compute, pointer read, data write, PC update, which takes 6 cycles.
- R10: Opcode 1110 follows the route fetch, decode, address compute, register write, PC update, which takes 5 cycles.
- R11: Opcodes 1000, 1101 and 1111 follow the route fetch, decode, PC update, which takes 3 cycles.
- R12: `opcode` is sampled only at the clock edge that leaves decode. Changes to it during any other phase do not alter the route.
- R13: Asserting `rst` in the middle of an instruction returns `phase` to fetch at the next edge, and a normal fetch then decode follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode of the fetched instruction, valid during decode |
| phase | output | 4 | Encoded current phase (see R1) |

## Verification
Two things happen on the same edge when the machine leaves decode. The phase register routes on the opcode as it stands at that moment, and the class register captures that same opcode for all later routing decisions. The bench makes this edge the only place where the opcode is correct. It holds a wrong opcode during fetch, puts the real one in place only while decode is showing, and then scrambles the opcode in every later cycle. A correct design must follow the route of the real opcode to the end, so a design that routes on the live input after decode, or that latches the opcode one cycle too early or too late, leaves its expected route at once.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int OPC_W   = 4;
    localparam int PHASE_W = 4;

    typedef enum logic [PHASE_W-1:0] {
        PH_FETCH  = 4'd0,
        PH_DECODE = 4'd1,
        PH_EXEC   = 4'd2,
        PH_ADDR   = 4'd3,
        PH_PTR_RD = 4'd4,
        PH_DAT_RD = 4'd5,
        PH_DAT_WR = 4'd6,
        PH_REG_WR = 4'd7,
        PH_LINK   = 4'd8,
        PH_PC_UPD = 4'd9
    } phase_e;

    typedef enum logic [3:0] {
        CL_NONE,
        CL_ALU,
        CL_BRANCH,
        CL_CALL,
        CL_LOAD,
        CL_STORE,
        CL_LOAD_IND,
        CL_STORE_IND,
        CL_ADDR_ONLY
    } iclass_e;

    typedef struct packed {
        phase_e  phase;
        iclass_e cls;
    } seq_regs_t;

endpackage

// File: rtl/op_class_dec.sv
module op_class_dec
    import seq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output iclass_e          cls
);

    always_comb begin
        unique case (opcode)
            4'b0001, 4'b0101, 4'b1001: cls = CL_ALU;
            4'b0000, 4'b1100:          cls = CL_BRANCH;
            4'b0100:                   cls = CL_CALL;
            4'b0010, 4'b0110:          cls = CL_LOAD;
            4'b0011, 4'b0111:          cls = CL_STORE;
            4'b1010:                   cls = CL_LOAD_IND;
            4'b1011:                   cls = CL_STORE_IND;
            4'b1110:                   cls = CL_ADDR_ONLY;
            default:                   cls = CL_NONE;
        endcase
    end

endmodule

// File: rtl/seq_next_phase.sv
module seq_next_phase
    import seq_pkg::*;
(
    input  phase_e  cur,
    input  iclass_e cls,
    output phase_e  nxt
);

    always_comb begin
        nxt = PH_FETCH;
        unique case (cur)
            PH_FETCH:  nxt = PH_DECODE;
            PH_DECODE: begin
                unique case (cls)
                    CL_ALU, CL_BRANCH, CL_CALL:               nxt = PH_EXEC;
                    CL_LOAD, CL_STORE, CL_LOAD_IND,
                    CL_STORE_IND, CL_ADDR_ONLY:               nxt = PH_ADDR;
                    default:                                  nxt = PH_PC_UPD;
                endcase
            end
            PH_EXEC: begin
                unique case (cls)
                    CL_ALU:  nxt = PH_REG_WR;
                    CL_CALL: nxt = PH_LINK;
                    default: nxt = PH_PC_UPD;
                endcase
            end
            PH_ADDR: begin
                unique case (cls)
                    CL_LOAD:                   nxt = PH_DAT_RD;
                    CL_STORE:                  nxt = PH_DAT_WR;
                    CL_LOAD_IND, CL_STORE_IND: nxt = PH_PTR_RD;
                    CL_ADDR_ONLY:              nxt = PH_REG_WR;
                    default:                   nxt = PH_PC_UPD;
                endcase
            end
            PH_PTR_RD: nxt = (cls == CL_STORE_IND) ? PH_DAT_WR : PH_DAT_RD;
            PH_DAT_RD: nxt = PH_REG_WR;
            PH_DAT_WR: nxt = PH_PC_UPD;
            PH_REG_WR: nxt = PH_PC_UPD;
            PH_LINK:   nxt = PH_PC_UPD;
            PH_PC_UPD: nxt = PH_FETCH;
            default:   nxt = PH_FETCH;
        endcase
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   opcode,
    output logic [PHASE_W-1:0] phase
);

    seq_regs_t regs_d, regs_q;
    iclass_e   cls_now;
    iclass_e   cls_route;
    phase_e    phase_nxt;

    op_class_dec u_dec (
        .opcode (opcode),
        .cls    (cls_now)
    );

    // In decode the fresh class routes; afterwards the held class does.
    assign cls_route = (regs_q.phase == PH_DECODE) ? cls_now : regs_q.cls;

    seq_next_phase u_nxt (
        .cur (regs_q.phase),
        .cls (cls_route),
        .nxt (phase_nxt)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.phase = phase_nxt;
        if (regs_q.phase == PH_DECODE) begin
            regs_d.cls = cls_now;
        end
        if (rst) begin
            regs_d.phase = PH_FETCH;
            regs_d.cls   = CL_NONE;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign phase = regs_q.phase;

    AST_RESET_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> regs_q.phase == PH_FETCH);                       // R1
    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
        regs_q.phase == PH_FETCH |=> regs_q.phase == PH_DECODE);        // R2
    AST_PCUPD_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        regs_q.phase == PH_PC_UPD |=> regs_q.phase == PH_FETCH);        // R2
    AST_PTR_ONLY_INDIRECT: assert property (@(posedge clk) disable iff (rst)
        regs_q.phase == PH_PTR_RD |->
            (regs_q.cls == CL_LOAD_IND || regs_q.cls == CL_STORE_IND)); // R8
    AST_WRITE_SKIPS_REG: assert property (@(posedge clk) disable iff (rst)
        regs_q.phase == PH_DAT_WR |=> regs_q.phase == PH_PC_UPD);       // R7
    AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
        regs_q.phase == PH_LINK |-> regs_q.cls == CL_CALL);             // R5
    AST_CLASS_HELD: assert property (@(posedge clk) disable iff (rst)
        (regs_q.phase != PH_DECODE && regs_q.phase != PH_PC_UPD) |=>
            $stable(regs_q.cls));                                       // R12
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        regs_q.phase <= PH_PC_UPD);                                     // R1

endmodule

// File: tb/seq_ctrl_tb.sv
`timescale 1ns/1ps
module seq_ctrl_tb;

    localparam int F = 0, D = 1, EX = 2, AD = 3, PR = 4, DR = 5, DW = 6, RW = 7, LK = 8, PU = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'h0;
    logic [3:0] phase;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seq_ctrl u_dut (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .phase  (phase)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected route per requirement; returns length.
    function automatic int route(input logic [3:0] op, output int p[8], output string req);
        for (int i = 0; i < 8; i++) p[i] = F;
        p[0] = F; p[1] = D;
        case (op)
            4'b0001, 4'b0101, 4'b1001: begin req = "R3";  p[2]=EX; p[3]=RW; p[4]=PU; return 5; end
            4'b0000, 4'b1100:          begin req = "R4";  p[2]=EX; p[3]=PU; return 4; end
            4'b0100:                   begin req = "R5";  p[2]=EX; p[3]=LK; p[4]=PU; return 5; end
            4'b0010, 4'b0110:          begin req = "R6";  p[2]=AD; p[3]=DR; p[4]=RW; p[5]=PU; return 6; end
            4'b0011, 4'b0111:          begin req = "R7";  p[2]=AD; p[3]=DW; p[4]=PU; return 5; end
            4'b1010:                   begin req = "R8";  p[2]=AD; p[3]=PR; p[4]=DR; p[5]=RW; p[6]=PU; return 7; end
            4'b1011:                   begin req = "R9";  p[2]=AD; p[3]=PR; p[4]=DW; p[5]=PU; return 6; end
            4'b1110:                   begin req = "R10"; p[2]=AD; p[3]=RW; p[4]=PU; return 5; end
            default:                   begin req = "R11"; p[2]=PU; return 3; end
        endcase
    endfunction

    // Called at a negedge while phase shows fetch.
    task automatic run_instr(input logic [3:0] op, input bit scramble);
        int p[8];
        string req;
        int len;
        len = route(op, p, req);
        check("R2", phase, F);
        opcode = scramble ? ~op : op;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (i == 1) opcode = op;
            else if (scramble) opcode = op ^ 4'(i * 5 + 3);
            check(scramble ? {req, "/R12"} : req, phase, p[i]);
        end
        @(negedge clk);
        check({req, "/R2"}, phase, F);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", phase, F);
        rst = 1'b0;
    endtask

    task automatic test_all_opcodes(input bit scramble);
        for (int k = 0; k < 16; k++) run_instr(4'(k), scramble);
    endtask

    task automatic test_mid_reset();
        opcode = 4'b1010;
        @(negedge clk); // decode
        @(negedge clk); // address compute
        check("R13", phase, AD);
        rst = 1'b1;
        @(negedge clk);
        check("R13", phase, F);
        rst = 1'b0;
        @(negedge clk);
        check("R13", phase, D);
        opcode = 4'b0011;
        @(negedge clk);
        check("R13", phase, AD);
        @(negedge clk);
        check("R13", phase, DW);
        @(negedge clk);
        check("R13", phase, PU);
        @(negedge clk);
        check("R13", phase, F);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_all_opcodes(1'b0);
        test_all_opcodes(1'b1);
        test_mid_reset();
        test_reset();
        run_instr(4'b1011, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule